// File: doc/BRIEF.md
# SDRAM Bank State and Precharge Tracker

This block sits inside an SDRAM controller, beside the command scheduler. Each cycle it may receive one decoded command: row open, read, write, precharge or burst stop. The command comes with a bank number and the address bit that selects the precharge variant. For every bank the block records whether a row is open and how many cycles remain before the bank has recovered from its last precharge. The scheduler uses the per-bank ready and open vectors to choose its next legal command. Any command that breaks the bank rules is flagged and has no effect.

Reads and writes can ask for an automatic precharge through the address bit. The tracker closes the bank itself when that burst ends. It starts the recovery count on the edge where an explicit precharge would first have been legal. The burst length, the recovery time and the full-page mode are parameters. In full-page mode the automatic precharge request is ignored, and a burst runs until something ends it.

Top module: `sdram_bank_tracker`

## Requirements
- R1: Command codes on `cmd_code`, taken only when `cmd_valid` is high, are: 0 no-op, 1 open row, 2 read, 3 write, 4 precharge, 5 burst stop. Codes 6 and 7 behave as no-op. `cmd_bank` selects the bank for open, read, write and single-bank precharge.
- R2: A precharge with `cmd_a10` high closes every bank and ignores `cmd_bank`. With `cmd_a10` low it closes only the selected bank. A precharge that reaches the bank of the running burst also ends that burst.
- R3: A read or write to a bank with no open row sets `cmd_err` for one cycle after the command edge and changes no state.
- R4: After a precharge on clock edge t, an open-row command to that bank is accepted from edge t+T_RP onward. An earlier attempt, or an attempt on an open bank, sets `cmd_err` and is ignored.
- R5: `bank_ready[b]` is high exactly when bank b has no open row and its recovery time has run out. After reset every bank is ready and none is open.
- R6: `cmd_a10` high on a read or write requests automatic precharge for that command only. A later read or write with `cmd_a10` low leaves the bank open.
- R7: With automatic precharge and a fixed burst length, a read or write on edge t closes its bank on edge t+BURST_LEN. An open-row command to that bank is accepted from edge t+BURST_LEN+T_RP onward.
- R8: When FULL_PAGE is set, automatic precharge is never applied and `burst_busy` stays high until the burst is ended by burst stop, a new read or write, or a precharge of its bank.
- R9: Burst stop ends the running burst on its edge. If that burst requested automatic precharge, its bank closes on that same edge.
- R10: A new accepted read or write ends the previous burst. If the previous burst requested automatic precharge, its bank closes on that edge.
- R11: A read or write to a bank whose running burst has automatic precharge pending sets `cmd_err` and is ignored.
- R12: `col_out` equals `cmd_col` at all times.
- R13: `burst_busy` rises on the edge that accepts a read or write. For a fixed-length burst it falls BURST_LEN edges later unless ended earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_code | input | 3 | Command code (see R1) |
| cmd_bank | input | BA_W | Bank number |
| cmd_a10 | input | 1 | All-bank precharge / automatic precharge select |
| cmd_col | input | COL_W | Column address |
| col_out | output | COL_W | Column address passed through |
| bank_open | output | NUM_BANKS | Row open per bank |
| bank_ready | output | NUM_BANKS | Bank may take an open-row command |
| burst_busy | output | 1 | A read or write burst is running |
| cmd_err | output | 1 | Previous command was illegal |

## Verification
The bench builds the tracker twice with four banks, a burst length of 4 and a recovery time of 3: one fixed-length instance and one full-page instance. The short burst and recovery windows let the bench sweep the open-row attempt across every distance from a precharge, in every bank, and land on each boundary edge. The same small settings reach the edges of automatic precharge closing and burst truncation within a few cycles. The full-page instance shows that automatic precharge is ignored and that a burst persists until it is stopped.

// File: rtl/sbt_pkg.sv
package sbt_pkg;

    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_ACT  = 3'd1,
        CMD_RD   = 3'd2,
        CMD_WR   = 3'd3,
        CMD_PRE  = 3'd4,
        CMD_BST  = 3'd5
    } sbt_cmd_e;

    // Effects one command has on one bank this edge
    typedef struct packed {
        logic open_req;
        logic close_req;
    } bank_ev_t;

    function automatic logic is_rw(input logic [2:0] code);
        return (code == CMD_RD) || (code == CMD_WR);
    endfunction

    function automatic sbt_cmd_e decode_op(input logic vld, input logic [2:0] code);
        sbt_cmd_e op;
        case (code)
            3'd1:    op = CMD_ACT;
            3'd2:    op = CMD_RD;
            3'd3:    op = CMD_WR;
            3'd4:    op = CMD_PRE;
            3'd5:    op = CMD_BST;
            default: op = CMD_NOP;
        endcase
        return vld ? op : CMD_NOP;
    endfunction

endpackage

// File: rtl/sbt_decode.sv
module sbt_decode
    import sbt_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BA_W      = 2
) (
    input  logic                 cmd_valid,
    input  logic [2:0]           cmd_code,
    input  logic [BA_W-1:0]      cmd_bank,
    input  logic                 cmd_a10,
    input  logic [NUM_BANKS-1:0] bank_open,
    input  logic [NUM_BANKS-1:0] bank_ready,
    input  logic [NUM_BANKS-1:0] ap_hot,
    output logic [NUM_BANKS-1:0] act_hit,
    output logic [NUM_BANKS-1:0] pre_hit,
    output logic                 rw_ok,
    output logic                 bst,
    output logic                 err
);
    sbt_cmd_e             op;
    logic [NUM_BANKS-1:0] sel;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_sel
        assign sel[b] = (cmd_bank == BA_W'(b));
    end

    always_comb begin
        op      = decode_op(cmd_valid, cmd_code);
        act_hit = '0;
        pre_hit = '0;
        rw_ok   = 1'b0;
        bst     = 1'b0;
        err     = 1'b0;
        case (op)
            CMD_ACT: begin
                act_hit = sel & bank_ready;
                err     = ~|(sel & bank_ready);
            end
            CMD_RD, CMD_WR: begin
                rw_ok = |(sel & bank_open & ~ap_hot);
                err   = ~rw_ok;
            end
            CMD_PRE: pre_hit = cmd_a10 ? '1 : sel;
            CMD_BST: bst = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/sbt_burst.sv
module sbt_burst #(
    parameter int NUM_BANKS = 4,
    parameter int BA_W      = 2,
    parameter int BURST_LEN = 4,
    parameter bit FULL_PAGE = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rw_ok,
    input  logic                 bst,
    input  logic [BA_W-1:0]      rw_bank,
    input  logic                 rw_a10,
    input  logic [NUM_BANKS-1:0] pre_hit,
    output logic                 busy,
    output logic [NUM_BANKS-1:0] ap_hot,
    output logic [NUM_BANKS-1:0] ap_fire
);
    localparam int BL_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;

    logic [BA_W-1:0] cur_bank;
    logic            cur_ap;
    logic [BL_W-1:0] left;
    logic            nat_end;
    logic            cut;
    logic            ends;

    assign nat_end = busy && !FULL_PAGE && (left == '0);
    assign cut     = bst || rw_ok;
    assign ends    = nat_end || cut || pre_hit[cur_bank];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_ap
        assign ap_hot[b]  = busy && cur_ap && (cur_bank == BA_W'(b));
        assign ap_fire[b] = ap_hot[b] && (nat_end || cut);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            cur_ap   <= 1'b0;
            cur_bank <= '0;
            left     <= '0;
        end else if (rw_ok) begin
            busy     <= 1'b1;
            cur_ap   <= rw_a10 && !FULL_PAGE;
            cur_bank <= rw_bank;
            left     <= BL_W'(BURST_LEN - 1);
        end else if (busy && ends) begin
            busy   <= 1'b0;
            cur_ap <= 1'b0;
        end else if (busy && !FULL_PAGE) begin
            left <= left - BL_W'(1);
        end
    end
endmodule

// File: rtl/sbt_bank.sv
module sbt_bank
    import sbt_pkg::*;
#(
    parameter int T_RP = 3
) (
    input  logic     clk,
    input  logic     rst,
    input  bank_ev_t ev,
    output logic     is_open,
    output logic     ready
);
    localparam int RP_W = (T_RP > 1) ? $clog2(T_RP) : 1;

    logic [RP_W-1:0] rp_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            is_open <= 1'b0;
            rp_cnt  <= '0;
        end else if (ev.close_req) begin
            is_open <= 1'b0;
            rp_cnt  <= RP_W'(T_RP - 1);
        end else if (ev.open_req) begin
            is_open <= 1'b1;
        end else if (rp_cnt != '0) begin
            rp_cnt <= rp_cnt - RP_W'(1);
        end
    end

    assign ready = !is_open && (rp_cnt == '0);
endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
    import sbt_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BURST_LEN = 4,
    parameter int T_RP      = 3,
    parameter bit FULL_PAGE = 1'b0,
    parameter int COL_W     = 10,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_valid,
    input  logic [2:0]           cmd_code,
    input  logic [BA_W-1:0]      cmd_bank,
    input  logic                 cmd_a10,
    input  logic [COL_W-1:0]     cmd_col,
    output logic [COL_W-1:0]     col_out,
    output logic [NUM_BANKS-1:0] bank_open,
    output logic [NUM_BANKS-1:0] bank_ready,
    output logic                 burst_busy,
    output logic                 cmd_err
);
    logic [NUM_BANKS-1:0] act_hit, pre_hit, ap_hot, ap_fire;
    logic                 rw_ok, bst, err_now;

    assign col_out = cmd_col;

    sbt_decode #(.NUM_BANKS(NUM_BANKS), .BA_W(BA_W)) dec_i (
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .cmd_bank  (cmd_bank),
        .cmd_a10   (cmd_a10),
        .bank_open (bank_open),
        .bank_ready(bank_ready),
        .ap_hot    (ap_hot),
        .act_hit   (act_hit),
        .pre_hit   (pre_hit),
        .rw_ok     (rw_ok),
        .bst       (bst),
        .err       (err_now)
    );

    sbt_burst #(
        .NUM_BANKS(NUM_BANKS), .BA_W(BA_W),
        .BURST_LEN(BURST_LEN), .FULL_PAGE(FULL_PAGE)
    ) burst_i (
        .clk    (clk),
        .rst    (rst),
        .rw_ok  (rw_ok),
        .bst    (bst),
        .rw_bank(cmd_bank),
        .rw_a10 (cmd_a10),
        .pre_hit(pre_hit),
        .busy   (burst_busy),
        .ap_hot (ap_hot),
        .ap_fire(ap_fire)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        bank_ev_t ev;
        assign ev.open_req  = act_hit[b];
        assign ev.close_req = pre_hit[b] | ap_fire[b];
        sbt_bank #(.T_RP(T_RP)) bank_i (
            .clk    (clk),
            .rst    (rst),
            .ev     (ev),
            .is_open(bank_open[b]),
            .ready  (bank_ready[b])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) cmd_err <= 1'b0;
        else     cmd_err <= err_now;
    end
endmodule

// File: rtl/sbt_checker.sv
module sbt_checker
    import sbt_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BA_W      = 2,
    parameter bit FULL_PAGE = 1'b0
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 cmd_valid,
    input logic [2:0]           cmd_code,
    input logic [BA_W-1:0]      cmd_bank,
    input logic                 cmd_a10,
    input logic [NUM_BANKS-1:0] bank_open,
    input logic [NUM_BANKS-1:0] bank_ready,
    input logic                 burst_busy,
    input logic                 cmd_err
);
    p_preall_closes_r2: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_code == CMD_PRE && cmd_a10 |=> bank_open == '0);

    p_rw_closed_err_r3: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && is_rw(cmd_code) && !bank_open[cmd_bank] |=> cmd_err);

    p_act_blocked_r4: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_code == CMD_ACT && !bank_ready[cmd_bank] |=> cmd_err);

    p_act_opens_r4: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_code == CMD_ACT && bank_ready[cmd_bank]
        |=> bank_open[$past(cmd_bank)] && !cmd_err);

    p_stop_ends_r9: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_code == CMD_BST |=> !burst_busy);

    p_busy_from_rw_r13: assert property (@(posedge clk) disable iff (rst)
        $rose(burst_busy) |-> $past(cmd_valid && is_rw(cmd_code)));

    if (FULL_PAGE) begin : g_fp
        p_fp_persists_r8: assert property (@(posedge clk) disable iff (rst)
            burst_busy && !cmd_valid |=> burst_busy);
    end
endmodule

bind sdram_bank_tracker sbt_checker #(
    .NUM_BANKS(NUM_BANKS), .BA_W(BA_W), .FULL_PAGE(FULL_PAGE)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .cmd_bank  (cmd_bank),
    .cmd_a10   (cmd_a10),
    .bank_open (bank_open),
    .bank_ready(bank_ready),
    .burst_busy(burst_busy),
    .cmd_err   (cmd_err)
);

// File: tb/sdram_bank_tracker_tb.sv
module sdram_bank_tracker_tb_top;
    localparam int NB  = 4;
    localparam int BL  = 4;
    localparam int TRP = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_code = 3'd0;
    logic [1:0]    cmd_bank = 2'd0;
    logic          cmd_a10 = 1'b0;
    logic [9:0]    cmd_col = 10'd0;
    logic [9:0]    col_out, col_out_fp;
    logic [NB-1:0] open_v, ready_v, open_fp, ready_fp;
    logic          busy, err, busy_fp, err_fp;

    int nvec = 0;
    int nbad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    sdram_bank_tracker #(.NUM_BANKS(NB), .BURST_LEN(BL), .T_RP(TRP), .FULL_PAGE(1'b0)) dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_bank(cmd_bank), .cmd_a10(cmd_a10), .cmd_col(cmd_col), .col_out(col_out),
        .bank_open(open_v), .bank_ready(ready_v), .burst_busy(busy), .cmd_err(err));

    sdram_bank_tracker #(.NUM_BANKS(NB), .BURST_LEN(BL), .T_RP(TRP), .FULL_PAGE(1'b1)) dut_fp_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_bank(cmd_bank), .cmd_a10(cmd_a10), .cmd_col(cmd_col), .col_out(col_out_fp),
        .bank_open(open_fp), .bank_ready(ready_fp), .burst_busy(busy_fp), .cmd_err(err_fp));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a falling edge; one rising edge takes the command
    task automatic issue(input logic [2:0] c, input int b, input bit a);
        cmd_valid = 1'b1; cmd_code = c; cmd_bank = 2'(b); cmd_a10 = a;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_code = 3'd0; cmd_a10 = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R5 reset state
        check("R5 reset open", open_v, 0);
        check("R5 reset ready", ready_v, 4'hF);
        check("R13 reset busy", busy, 0);
        check("R3 reset err", err, 0);

        // R1 bank select for open-row, cumulative
        for (int b = 0; b < NB; b++) begin
            issue(3'd1, b, 0);
            check("R1 open select", open_v, (32'd1 << (b + 1)) - 1);
            check("R1 open no err", err, 0);
        end

        // R1 unused codes act as no-op
        issue(3'd7, 1, 1);
        check("R1 code7 no err", err, 0);
        check("R1 code7 no change", open_v, 4'hF);

        // R2 single then all-bank precharge
        issue(3'd4, 2, 0);
        check("R2 single pre", open_v, 4'b1011);
        issue(3'd4, 2, 1);
        check("R2 all pre", open_v, 0);
        check("R5 recovering", ready_v, 0);
        idle(TRP - 1);
        check("R5 recovered", ready_v, 4'hF);

        // R3 read/write to closed bank
        issue(3'd2, 1, 0);
        check("R3 read closed err", err, 1);
        check("R3 read closed state", open_v, 0);
        issue(3'd3, 3, 0);
        check("R3 write closed err", err, 1);
        idle(1);
        check("R3 err pulse", err, 0);

        // R4 sweep open-row distance after precharge, every bank
        for (int b = 0; b < NB; b++) issue(3'd1, b, 0);
        for (int b = 0; b < NB; b++) begin
            for (int k = 1; k <= TRP + 1; k++) begin
                issue(3'd4, b, 0);
                check("R5 closed not ready", ready_v[b], 0);
                idle(k - 1);
                issue(3'd1, b, 0);
                check("R4 act err vs distance", err, (k < TRP) ? 1 : 0);
                check("R4 act open vs distance", open_v[b], (k < TRP) ? 0 : 1);
                if (k < TRP) begin
                    idle(TRP);
                    issue(3'd1, b, 0);
                end
            end
        end
        issue(3'd1, 0, 0);
        check("R4 act open bank err", err, 1);

        // R7 R13 automatic precharge at end of fixed burst
        issue(3'd4, 0, 1);
        idle(TRP - 1);
        issue(3'd1, 0, 0);
        issue(3'd2, 0, 1);
        check("R13 busy rises", busy, 1);
        idle(BL - 1);
        check("R7 still open", open_v[0], 1);
        check("R13 busy holds", busy, 1);
        idle(1);
        check("R7 closed at end", open_v[0], 0);
        check("R13 busy falls", busy, 0);
        check("R7 not ready", ready_v[0], 0);
        idle(TRP - 2);
        issue(3'd1, 0, 0);
        check("R7 early act err", err, 1);
        issue(3'd1, 0, 0);
        check("R7 act on time", open_v[0], 1);
        check("R7 act on time no err", err, 0);

        // R6 request not persistent
        issue(3'd3, 0, 0);
        idle(BL + TRP);
        check("R6 stays open", open_v[0], 1);

        // R11 command to bank with pending auto precharge
        issue(3'd2, 0, 1);
        issue(3'd3, 0, 0);
        check("R11 pending ap err", err, 1);
        idle(BL - 1);
        check("R11 closes on schedule", open_v[0], 0);
        idle(TRP);
        issue(3'd1, 0, 0);

        // R9 burst stop with and without auto precharge
        issue(3'd1, 1, 0);
        issue(3'd2, 1, 1);
        issue(3'd5, 0, 0);
        check("R9 stop closes ap bank", open_v[1], 0);
        check("R9 stop ends burst", busy, 0);
        idle(TRP - 1);
        check("R9 recovery from stop", ready_v[1], 1);
        issue(3'd1, 1, 0);
        issue(3'd2, 1, 0);
        issue(3'd5, 0, 0);
        check("R9 plain stop busy", busy, 0);
        check("R9 plain stop open", open_v[1], 1);

        // R10 new burst cuts previous one
        issue(3'd2, 0, 1);
        issue(3'd3, 1, 0);
        check("R10 prior ap bank closed", open_v[0], 0);
        check("R10 new bank open", open_v[1], 1);
        check("R10 busy", busy, 1);
        idle(BL - 1);
        check("R13 busy to end", busy, 1);
        idle(1);
        check("R13 busy end", busy, 0);

        // R2 precharge of burst bank ends burst
        idle(TRP);
        issue(3'd1, 0, 0);
        issue(3'd2, 1, 0);
        issue(3'd4, 1, 0);
        check("R2 pre ends burst", busy, 0);
        check("R2 pre closes bank", open_v, 4'b0001);

        // R12 column pass-through
        for (int i = 0; i < 10; i++) begin
            cmd_col = 10'(1 << i) ^ 10'h2A5;
            #1;
            check("R12 col", col_out, 10'(1 << i) ^ 10'h2A5);
        end

        // R8 full-page instance
        do_reset();
        issue(3'd1, 2, 0);
        issue(3'd2, 2, 1);
        idle(BL + TRP + 2);
        check("R8 fp busy persists", busy_fp, 1);
        check("R8 fp no ap", open_fp[2], 1);
        issue(3'd5, 0, 0);
        check("R8 fp stop busy", busy_fp, 0);
        check("R8 fp stop open", open_fp[2], 1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule